// File: doc/BRIEF.md
# Sequential Shift-Add and Booth Multiplier

This block multiplies two N-bit operands over N clock cycles and returns a 2N-bit product, examining one multiplier bit per cycle. A mode input chosen at start selects plain unsigned shift-and-add or signed radix-2 Booth recoding. The datapath is one N-bit accumulator (the high product half) and one N-bit register that holds the multiplier at first and fills with low product bits as the multiplier bits are used up. No separate product register exists.

A client raises `start` for one cycle with the operands and the mode. The block answers with `busy` for N cycles and then a one-cycle `done` pulse. The product and the overflow flag stay put until the next accepted start. Signed mode keeps an N-bit accumulator, so a multiplicand equal to the most negative N-bit value can overflow it. The block raises `ovf` for that operand so the client can discard the result.

The control is a three-state machine. ST_IDLE goes to ST_RUN on start and otherwise stays. ST_RUN stays while the iteration counter has not reached its last step and moves to ST_DONE on the last step. ST_DONE lasts one cycle: it goes to ST_RUN when start is high and to ST_IDLE otherwise.

Top module: `seq_mult_core`

## Requirements
- R1: A start sampled while `busy` is low is accepted. `busy` is then high for exactly N cycles, starting the cycle after the start edge. `done` is high for exactly the one cycle after `busy` falls.
- R2: With `signed_mode`=0 the product is the unsigned product of `mcand` and `mplier`, zero-extended to 2N bits.
- R3: With `signed_mode`=1, and `mcand` not equal to 1 followed by N-1 zeros, the product is the two's-complement product of both operands as a 2N-bit value.
- R4: On an accepted start, `ovf` becomes 1 if `signed_mode`=1 and `mcand` has only its MSB set, and 0 otherwise.
- R5: A start raised while `busy` is high has no effect. The operands and the mode are not recaptured and the run is not restarted.
- R6: `product` and `ovf` stay unchanged from the `done` cycle until the next accepted start.
- R7: A synchronous active-high `rst` clears `busy`, `done`, `ovf` and `product` to zero.
- R8: These products are returned. At N=8: 250×4 gives 0x03E8 unsigned, and −99×88 gives 0xDDF8 signed. At N=16: 5050×10000 gives 0x030291A0 unsigned, and −12345×−4321 gives 0x032DF219 signed.
- R9: A start presented in the `done` cycle is accepted, and the next run begins with no idle cycle between the runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request; operands and mode are captured when accepted |
| signed_mode | input | 1 | 1 = signed Booth, 0 = unsigned shift-and-add |
| mcand | input | N | Multiplicand |
| mplier | input | N | Multiplier |
| busy | output | 1 | High while iterations run |
| done | output | 1 | One-cycle pulse when the product is valid |
| product | output | 2N | Double-width product |
| ovf | output | 1 | Most-negative multiplicand seen in signed mode |

## Verification
The hardest situations to reach are the ones that overlap a run boundary. These are a start that arrives during a run, which must be ignored, and a start that arrives in the `done` cycle itself, which must be taken. The stimulus raises `start` with different operands and the opposite mode one cycle into a run. It also issues most operations directly in the `done` cycle, with random idle gaps in between. Operands include 0, all-ones, the most negative and the most positive values in both modes. Two widths run side by side, and every cycle is compared against a behavioural model.

// File: rtl/seq_mult_pkg.sv
package seq_mult_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } mult_state_e;

endpackage

// File: rtl/seq_mult_count.sv
module seq_mult_count #(
    parameter int N = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic step,
    output logic last
);
    localparam int CW = $clog2(N + 1);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= CW'(N);
        end else if (step) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign last = (left_q == CW'(1));
endmodule

// File: rtl/seq_mult_fsm.sv
module seq_mult_fsm
    import seq_mult_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic last,
    output logic busy,
    output logic done,
    output logic load,
    output logic step
);
    mult_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = start ? ST_RUN : ST_IDLE;
            ST_RUN:  state_d = last ? ST_DONE : ST_RUN;
            ST_DONE: state_d = start ? ST_RUN : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        load = 1'b0;
        step = 1'b0;
        unique case (state_q)
            ST_IDLE: load = start;
            ST_RUN: begin
                busy = 1'b1;
                step = 1'b1;
            end
            ST_DONE: begin
                done = 1'b1;
                load = start;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/seq_mult_step.sv
module seq_mult_step #(
    parameter int N = 8
) (
    input  logic         booth,
    input  logic [N-1:0] hi,
    input  logic [N-1:0] lo,
    input  logic         flag,
    input  logic [N-1:0] mcand,
    output logic [N-1:0] hi_n,
    output logic [N-1:0] lo_n,
    output logic         flag_n
);
    logic [N:0]   sum_u;
    logic [N-1:0] acc_s;
    logic [N-1:0] add_term;
    logic [N-1:0] sub_term;

    always_comb begin
        add_term = flag ? mcand : '0;
        sub_term = lo[0] ? mcand : '0;
        // unsigned: carry out of the add becomes the new MSB
        sum_u = {1'b0, hi} + {1'b0, add_term};
        // Booth pair: previous bit adds, current bit subtracts
        acc_s = hi + add_term - sub_term;
        if (booth) begin
            hi_n = {acc_s[N-1], acc_s[N-1:1]};
            lo_n = {acc_s[0], lo[N-1:1]};
        end else begin
            hi_n = sum_u[N:1];
            lo_n = {sum_u[0], lo[N-1:1]};
        end
        flag_n = lo[0];
    end
endmodule

// File: rtl/seq_mult_datapath.sv
module seq_mult_datapath #(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           step,
    input  logic           signed_mode,
    input  logic [N-1:0]   mcand,
    input  logic [N-1:0]   mplier,
    output logic [2*N-1:0] product,
    output logic           ovf
);
    localparam logic [N-1:0] MOST_NEG = {1'b1, {(N-1){1'b0}}};

    logic [N-1:0] hi_q, lo_q, mcand_q;
    logic         flag_q, booth_q, ovf_q;
    logic [N-1:0] hi_n, lo_n;
    logic         flag_n;

    seq_mult_step #(.N(N)) step_i (
        .booth  (booth_q),
        .hi     (hi_q),
        .lo     (lo_q),
        .flag   (flag_q),
        .mcand  (mcand_q),
        .hi_n   (hi_n),
        .lo_n   (lo_n),
        .flag_n (flag_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q    <= '0;
            lo_q    <= '0;
            mcand_q <= '0;
            flag_q  <= 1'b0;
            booth_q <= 1'b0;
            ovf_q   <= 1'b0;
        end else if (load) begin
            hi_q    <= '0;
            mcand_q <= mcand;
            booth_q <= signed_mode;
            ovf_q   <= signed_mode && (mcand == MOST_NEG);
            if (signed_mode) begin
                lo_q   <= mplier;
                flag_q <= 1'b0;
            end else begin
                lo_q   <= {1'b0, mplier[N-1:1]};
                flag_q <= mplier[0];
            end
        end else if (step) begin
            hi_q   <= hi_n;
            lo_q   <= lo_n;
            flag_q <= flag_n;
        end
    end

    assign product = {hi_q, lo_q};
    assign ovf     = ovf_q;
endmodule

// File: rtl/seq_mult_core.sv
module seq_mult_core #(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic           signed_mode,
    input  logic [N-1:0]   mcand,
    input  logic [N-1:0]   mplier,
    output logic           busy,
    output logic           done,
    output logic [2*N-1:0] product,
    output logic           ovf
);
    logic load, step, last;

    seq_mult_fsm fsm_i (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .last  (last),
        .busy  (busy),
        .done  (done),
        .load  (load),
        .step  (step)
    );

    seq_mult_count #(.N(N)) count_i (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .step (step),
        .last (last)
    );

    seq_mult_datapath #(.N(N)) dp_i (
        .clk         (clk),
        .rst         (rst),
        .load        (load),
        .step        (step),
        .signed_mode (signed_mode),
        .mcand       (mcand),
        .mplier      (mplier),
        .product     (product),
        .ovf         (ovf)
    );
endmodule

// File: rtl/seq_mult_chk.sv
module seq_mult_chk #(
    parameter int N = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic           signed_mode,
    input logic [N-1:0]   mcand,
    input logic [N-1:0]   mplier,
    input logic           busy,
    input logic           done,
    input logic [2*N-1:0] product,
    input logic           ovf
);
    localparam int CW = $clog2(N + 1) + 1;
    localparam logic [N-1:0] MOST_NEG = {1'b1, {(N-1){1'b0}}};

    logic [CW-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            run_len <= '0;
        end else begin
            run_len <= run_len + 1'b1;
        end
    end

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy); // R1
    AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run_len == CW'(N))); // R1
    AST_DONE_FOLLOWS_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) && !busy)); // R1
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R1
    AST_OVF_RULE: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (ovf == $past(signed_mode && (mcand == MOST_NEG)))); // R4
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> ($stable(ovf) && (busy || done))); // R5
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(product) && $stable(ovf))); // R6
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!busy && !done && !ovf && (product == '0))); // R7
    AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
        (done && start) |=> busy); // R9
endmodule

bind seq_mult_core seq_mult_chk #(.N(N)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .signed_mode (signed_mode),
    .mcand       (mcand),
    .mplier      (mplier),
    .busy        (busy),
    .done        (done),
    .product     (product),
    .ovf         (ovf)
);

// File: tb/seq_mult_core_tb.sv
module seq_mult_core_tb_lane #(
    parameter int N = 8
) (
    input  logic clk,
    input  logic rst,
    output int   n_chk,
    output int   n_fail,
    output bit   fin
);
    localparam logic [N-1:0] MOST_NEG = {1'b1, {(N-1){1'b0}}};
    localparam logic [N-1:0] MOST_POS = {1'b0, {(N-1){1'b1}}};

    logic           start, sm_i;
    logic [N-1:0]   op_a, op_b;
    logic           busy, done, ovf;
    logic [2*N-1:0] product;

    seq_mult_core #(.N(N)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .signed_mode (sm_i),
        .mcand       (op_a),
        .mplier      (op_b),
        .busy        (busy),
        .done        (done),
        .product     (product),
        .ovf         (ovf)
    );

    function automatic logic [2*N-1:0] ref_prod(input logic [N-1:0] a, input logic [N-1:0] b,
                                                input bit sm);
        longint pa, pb, pr;
        if (sm) begin
            pa = longint'($signed(a));
            pb = longint'($signed(b));
        end else begin
            pa = longint'(a);
            pb = longint'(b);
        end
        pr = pa * pb;
        return pr[2*N-1:0];
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s N=%0d %s act=%0h exp=%0h", tag, N, what, act, exp);
        end
    endtask

    // behavioural model, advanced on every rising edge
    bit             m_busy, m_done, m_ovf, m_mode, m_skip, m_valid;
    int             m_left;
    logic [2*N-1:0] m_prod;

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_done = 0; m_ovf = 0; m_left = 0;
            m_prod = '0; m_valid = 1; m_skip = 0; m_mode = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_left--;
                if (m_left == 0) begin
                    m_busy  = 0;
                    m_done  = 1;
                    m_valid = !m_skip;
                end
            end else if (start) begin
                m_busy  = 1;
                m_left  = N;
                m_valid = 0;
                m_mode  = sm_i;
                m_ovf   = sm_i && (op_a == MOST_NEG);
                m_skip  = m_ovf;
                m_prod  = ref_prod(op_a, op_b, sm_i);
            end
        end
    end

    // compare every cycle, away from the rising edge
    always @(negedge clk) begin
        string t_ctl, t_ovf, t_prod;
        t_ctl  = rst ? "R7" : "R1";
        t_ovf  = rst ? "R7" : "R4";
        t_prod = rst ? "R7" : (m_done ? (m_mode ? "R3" : "R2") : "R6");
        chk(busy == m_busy, t_ctl, "busy", longint'(busy), longint'(m_busy));
        chk(done == m_done, t_ctl, "done", longint'(done), longint'(m_done));
        chk(ovf == m_ovf, t_ovf, "ovf", longint'(ovf), longint'(m_ovf));
        if (m_valid)
            chk(product == m_prod, t_prod, "product", longint'(product), longint'(m_prod));
    end

    // called at a falling edge; returns at the falling edge of the done cycle
    task automatic do_op(input logic [N-1:0] a, input logic [N-1:0] b, input bit sm,
                         input bit junk);
        start = 1; op_a = a; op_b = b; sm_i = sm;
        @(posedge clk); #1;
        start = 0;
        if (junk) begin
            start = 1; op_a = ~a; op_b = b + 1'b1; sm_i = !sm;
            @(posedge clk); #1;
            start = 0;
        end
        do @(negedge clk); while (!done);
        if (junk && !(sm && a == MOST_NEG))
            chk(product == ref_prod(a, b, sm), "R5", "product after ignored start",
                longint'(product), longint'(ref_prod(a, b, sm)));
    endtask

    initial begin
        logic [N-1:0] corner [4];
        n_chk = 0; n_fail = 0; fin = 0;
        start = 0; sm_i = 0; op_a = '0; op_b = '0;
        corner[0] = '0; corner[1] = '1; corner[2] = MOST_NEG; corner[3] = MOST_POS;
        wait (rst == 1'b0);
        @(negedge clk);
        chk(!busy && !done && !ovf && product == '0, "R7", "state after reset",
            longint'({busy, done, ovf}), 0);
        // fixed results (R8); first one started from idle, rest back to back (R9)
        if (N == 8) begin
            do_op(N'(250), N'(4), 1'b0, 1'b0);
            chk(product == (2*N)'(32'h03E8), "R8", "250x4", longint'(product), 64'h03E8);
            do_op(N'(-99), N'(88), 1'b1, 1'b0);
            chk(product == (2*N)'(32'hDDF8), "R8", "-99x88", longint'(product), 64'hDDF8);
        end else begin
            do_op(N'(5050), N'(10000), 1'b0, 1'b0);
            chk(product == (2*N)'(32'h030291A0), "R8", "5050x10000",
                longint'(product), 64'h030291A0);
            do_op(N'(-12345), N'(-4321), 1'b1, 1'b0);
            chk(product == (2*N)'(32'h032DF219), "R8", "-12345x-4321",
                longint'(product), 64'h032DF219);
        end
        // a start raised in the done cycle must begin a run at once (R9)
        start = 1; op_a = N'(3); op_b = N'(5); sm_i = 0;
        @(posedge clk); #1;
        start = 0;
        chk(busy == 1'b1, "R9", "busy after start in done cycle", longint'(busy), 1);
        do @(negedge clk); while (!done);
        // corner operands in both modes, with ignored starts mixed in (R5)
        for (int m = 0; m < 2; m++)
            for (int i = 0; i < 4; i++)
                for (int j = 0; j < 4; j++) begin
                    do_op(corner[i], corner[j], m[0], ((i + j) % 3) == 0);
                    if (m == 1 && i == 2)
                        chk(ovf == 1'b1, "R4", "ovf on most negative", longint'(ovf), 1);
                end
        // random operands with random idle gaps (R2, R3, R6)
        for (int k = 0; k < 150; k++) begin
            int gap;
            gap = int'($urandom_range(0, 2));
            repeat (gap) @(negedge clk);
            do_op(N'($urandom), N'($urandom), 1'($urandom), ($urandom_range(0, 4) == 0));
        end
        repeat (3) @(negedge clk);
        fin = 1;
    end
endmodule

module seq_mult_core_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    int   c8, f8, c16, f16;
    bit   d8, d16;
    int   wd_fail = 0;

    always #5 clk = ~clk;

    seq_mult_core_tb_lane #(.N(8))  lane8_i  (.clk(clk), .rst(rst), .n_chk(c8),  .n_fail(f8),  .fin(d8));
    seq_mult_core_tb_lane #(.N(16)) lane16_i (.clk(clk), .rst(rst), .n_chk(c16), .n_fail(f16), .fin(d16));

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!(d8 && d16) && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!(d8 && d16)) begin
            wd_fail = 1;
            $display("FAIL watchdog: run did not finish act=%0d exp=done", cyc);
        end
        $display("End of test - %0d assertions evaluated, %0d failures",
                 c8 + c16 + wd_fail, f8 + f16 + wd_fail);
        $finish;
    end
endmodule